// File: doc/BRIEF.md
# Tagged Next-Block Prefetcher

This block sits beside a small direct-mapped cache and watches its demand accesses. For an access to block address b it may ask the memory side for block b+1. It keeps a shadow directory that mirrors the cache's line fills. Each line in the directory holds a valid flag, the upper address bits, and one extra "prefetched but not yet referenced" bit. The directory has two uses. It decides whether a hit should re-arm the stream. It also suppresses a request for a block that the cache already holds.

Two trigger policies are available, chosen by `mode_tagged_i`. With the input low, only a miss starts a prefetch. With the input high, a miss also starts one, and so does the first hit to a line that arrived by prefetch. That hit also clears the line's tag bit, so a sequential stream stays one block ahead. Requests go out through a single-entry valid/ready holding register. A newer trigger replaces a request that has not yet been accepted.

Top module: `tagged_next_prefetcher`

## Requirements
- R1: The request address is the accessed block address plus one, modulo 2^ADDR_W. `pf_valid_o` rises on the clock edge that samples the triggering access.
- R2: In either mode, a miss (`acc_valid_i`=1, `acc_hit_i`=0) triggers a request, unless R7 applies.
- R3: With `mode_tagged_i`=0, a hit never triggers a request.
- R4: A fill with `fill_pf_i`=1 sets the filled line's tag bit. A fill with `fill_pf_i`=0 clears it, including when the same block is refilled.
- R5: With `mode_tagged_i`=1, a hit to a line whose tag bit is set triggers a request. A second hit to the same line does not.
- R6: With `mode_tagged_i`=1, a hit to a line whose tag bit is 0 triggers no request.
- R7: No request is made when block b+1 is resident. Resident means its line, at index (b+1) mod 2^IDX_W, is valid and holds the same upper address bits.
- R8: While `pf_valid_o`=1 and `pf_ready_i`=0, the request stays valid. Its address stays unchanged unless a new trigger arrives.
- R9: A new trigger that arrives while a request is waiting replaces the waiting request's address.
- R10: After reset, `pf_valid_o` is 0 and every directory line is invalid, so no block counts as resident.
- R11: The first hit to a prefetched line clears its tag bit in either mode. A line that is first referenced while the prefetcher is in miss-only mode does not trigger later in tagged mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_tagged_i | input | 1 | 0: miss-only trigger, 1: tagged trigger |
| acc_valid_i | input | 1 | Demand access present |
| acc_addr_i | input | ADDR_W | Demand block address |
| acc_hit_i | input | 1 | Cache hit for the access |
| fill_valid_i | input | 1 | A line is being filled |
| fill_addr_i | input | ADDR_W | Block address of the fill |
| fill_pf_i | input | 1 | 1: fill came from a prefetch, 0: demand fill |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | ADDR_W | Prefetch request block address |
| pf_ready_i | input | 1 | Memory side accepts the request |

## Verification
The bench replays short sequential runs under each mode. Misses alone show that both policies issue b+1. Hits on demand-filled and prefetch-filled lines separate tagged behaviour from miss-only behaviour. Repeated hits on one prefetched line, and a refill that changes its origin, show the tag bit being cleared and rewritten. Further cases cover a resident successor, matched against a successor that only shares its index, and an access to the top address, which shows wraparound. A stalled memory side with back-to-back triggers tells holding apart from replacement.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    MODE_MISS_ONLY = 1'b0,
    MODE_TAGGED    = 1'b1
  } pf_mode_e;
endpackage

// File: rtl/pf_line_dir.sv
module pf_line_dir #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  input  logic              clr_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              fill_pf_i,
  output logic              look_tagged_o,
  output logic              next_resident_o
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             vld_q [LINES];
  logic             pf_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  logic [ADDR_W-1:0] nxt_addr;
  logic [IDX_W-1:0]  look_idx, nxt_idx, fill_idx;
  logic [TAG_W-1:0]  look_tag, nxt_tag, fill_tag;

  assign nxt_addr = look_addr_i + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign look_idx = look_addr_i[IDX_W-1:0];
  assign look_tag = look_addr_i[ADDR_W-1:IDX_W];
  assign nxt_idx  = nxt_addr[IDX_W-1:0];
  assign nxt_tag  = nxt_addr[ADDR_W-1:IDX_W];
  assign fill_idx = fill_addr_i[IDX_W-1:0];
  assign fill_tag = fill_addr_i[ADDR_W-1:IDX_W];

  assign look_tagged_o   = vld_q[look_idx] && (tag_q[look_idx] == look_tag) && pf_q[look_idx];
  assign next_resident_o = vld_q[nxt_idx] && (tag_q[nxt_idx] == nxt_tag);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    // fill has priority over a tag clear on the same line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        pf_q[i]  <= 1'b0;
        tag_q[i] <= '0;
      end else if (fill_valid_i && fill_idx == IDX_W'(i)) begin
        vld_q[i] <= 1'b1;
        pf_q[i]  <= fill_pf_i;
        tag_q[i] <= fill_tag;
      end else if (clr_i && look_idx == IDX_W'(i)) begin
        pf_q[i]  <= 1'b0;
      end
    end
  end

  AST_CLR_IS_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> look_tagged_o); // R11
endmodule

// File: rtl/pf_trigger.sv
module pf_trigger
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  pf_mode_e          mode_i,
  input  logic              acc_valid_i,
  input  logic              acc_hit_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              line_tagged_i,
  input  logic              next_resident_i,
  output logic              fire_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] tgt_addr_o
);
  logic first_use, want;

  assign first_use  = acc_valid_i && acc_hit_i && line_tagged_i;
  assign clr_o      = first_use;
  assign want       = acc_valid_i && (!acc_hit_i || (mode_i == MODE_TAGGED && first_use));
  assign fire_o     = want && !next_resident_i;
  assign tgt_addr_o = acc_addr_i + {{(ADDR_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pf_req_hold.sv
module pf_req_hold #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= load_addr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o); // R8
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !load_i |=> $stable(addr_o)); // R8
endmodule

// File: rtl/tagged_next_prefetcher.sv
module tagged_next_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_tagged_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_hit_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              fill_pf_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i
);
  logic              line_tagged, next_res, fire, clr;
  logic [ADDR_W-1:0] tgt_addr;
  pf_mode_e          mode;

  assign mode = pf_mode_e'(mode_tagged_i);

  pf_line_dir #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dir (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .look_addr_i    (acc_addr_i),
    .clr_i          (clr),
    .fill_valid_i   (fill_valid_i),
    .fill_addr_i    (fill_addr_i),
    .fill_pf_i      (fill_pf_i),
    .look_tagged_o  (line_tagged),
    .next_resident_o(next_res)
  );

  pf_trigger #(.ADDR_W(ADDR_W)) u_trig (
    .mode_i         (mode),
    .acc_valid_i    (acc_valid_i),
    .acc_hit_i      (acc_hit_i),
    .acc_addr_i     (acc_addr_i),
    .line_tagged_i  (line_tagged),
    .next_resident_i(next_res),
    .fire_o         (fire),
    .clr_o          (clr),
    .tgt_addr_o     (tgt_addr)
  );

  pf_req_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fire),
    .load_addr_i(tgt_addr),
    .ready_i    (pf_ready_i),
    .valid_o    (pf_valid_o),
    .addr_o     (pf_addr_o)
  );

  AST_MISS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_hit_i && !next_res |=>
      pf_valid_o && pf_addr_o == $past(acc_addr_i) + {{(ADDR_W-1){1'b0}}, 1'b1}); // R2
  AST_MISSONLY_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_hit_i && !mode_tagged_i && !pf_valid_o |=> !pf_valid_o); // R3
  AST_RESIDENT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && next_res && !pf_valid_o |=> !pf_valid_o); // R7
  AST_TAGGED_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_hit_i && mode_tagged_i && line_tagged && !next_res |=> pf_valid_o); // R5
endmodule

// File: tb/sim_tagged_next_prefetcher.sv
`timescale 1ns/1ps
module sim_tagged_next_prefetcher;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_t = 1'b0;
  logic          acc_v = 1'b0;
  logic [AW-1:0] acc_a = '0;
  logic          acc_h = 1'b0;
  logic          fill_v = 1'b0;
  logic [AW-1:0] fill_a = '0;
  logic          fill_p = 1'b0;
  logic          pf_v;
  logic [AW-1:0] pf_a;
  logic          pf_rdy = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tagged_next_prefetcher #(.ADDR_W(AW), .IDX_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_tagged_i(mode_t),
    .acc_valid_i(acc_v), .acc_addr_i(acc_a), .acc_hit_i(acc_h),
    .fill_valid_i(fill_v), .fill_addr_i(fill_a), .fill_pf_i(fill_p),
    .pf_valid_o(pf_v), .pf_addr_o(pf_a), .pf_ready_i(pf_rdy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_none(input string req);
    chk(pf_v == 1'b0, req, {31'b0, pf_v}, 32'd0);
  endtask

  task automatic chk_req(input string req, input logic [AW-1:0] exp);
    chk(pf_v == 1'b1 && pf_a == exp, req, {15'b0, pf_v, pf_a}, {15'b0, 1'b1, exp});
  endtask

  // one-cycle access; on return the registered result is visible
  task automatic access(input logic [AW-1:0] a, input logic hit);
    @(negedge clk);
    acc_v = 1'b1; acc_a = a; acc_h = hit;
    @(negedge clk);
    acc_v = 1'b0; acc_h = 1'b0;
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic pf);
    @(negedge clk);
    fill_v = 1'b1; fill_a = a; fill_p = pf;
    @(negedge clk);
    fill_v = 1'b0; fill_p = 1'b0;
  endtask

  task automatic t_reset();
    chk_none("R10 reset valid");
    mode_t = 1'b0;
    access(16'h0010, 1'b0);
    chk_req("R10 empty dir / R1 next addr", 16'h0011);
  endtask

  task automatic t_miss_only();
    mode_t = 1'b0;
    fill(16'h0010, 1'b0);
    fill(16'h0011, 1'b1);
    access(16'h0010, 1'b1);
    chk_none("R3 hit demand line");
    access(16'h0011, 1'b1);
    chk_none("R3 hit prefetched line");
    access(16'h0012, 1'b0);
    chk_req("R2 miss-only miss", 16'h0013);
  endtask

  task automatic t_tagged();
    mode_t = 1'b1;
    fill(16'h0020, 1'b0);
    fill(16'h0021, 1'b1);
    access(16'h0020, 1'b1);
    chk_none("R6 hit untagged");
    access(16'h0021, 1'b1);
    chk_req("R5 first hit rearms", 16'h0022);
    access(16'h0021, 1'b1);
    chk_none("R5 second hit quiet");
    access(16'h0025, 1'b0);
    chk_req("R2 tagged miss", 16'h0026);
  endtask

  task automatic t_refill();
    mode_t = 1'b1;
    fill(16'h0062, 1'b1);
    fill(16'h0062, 1'b0);
    access(16'h0062, 1'b1);
    chk_none("R4 demand refill clears bit");
    fill(16'h0062, 1'b1);
    access(16'h0062, 1'b1);
    chk_req("R4 prefetch fill sets bit", 16'h0063);
  endtask

  task automatic t_resident();
    mode_t = 1'b1;
    fill(16'h0041, 1'b0);
    access(16'h0040, 1'b0);
    chk_none("R7 successor resident");
    fill(16'h0051, 1'b0);
    access(16'h0040, 1'b0);
    chk_req("R7 same index other tag", 16'h0041);
  endtask

  task automatic t_wrap();
    mode_t = 1'b0;
    access(16'hFFFF, 1'b0);
    chk_req("R1 wrap", 16'h0000);
  endtask

  task automatic t_mode_clear();
    fill(16'h0071, 1'b1);
    mode_t = 1'b0;
    access(16'h0071, 1'b1);
    chk_none("R11 miss-only first hit");
    mode_t = 1'b1;
    access(16'h0071, 1'b1);
    chk_none("R11 bit already cleared");
  endtask

  task automatic t_backpressure();
    mode_t = 1'b0;
    pf_rdy = 1'b0;
    access(16'h0100, 1'b0);
    chk_req("R8 request raised", 16'h0101);
    repeat (3) @(negedge clk);
    chk_req("R8 held while stalled", 16'h0101);
    access(16'h0200, 1'b0);
    chk_req("R9 overwrite", 16'h0201);
    @(negedge clk);
    chk_req("R8 still held", 16'h0201);
    pf_rdy = 1'b1;
    @(negedge clk);
    chk_none("R8 released on ready");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_only();
    t_tagged();
    t_refill();
    t_resident();
    t_wrap();
    t_mode_clear();
    t_backpressure();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule